// File: doc/BRIEF.md
# Victim Cache Side Buffer

This block is a small, fully-associative store next to a direct-mapped first-level cache. It holds the blocks that the first-level cache has recently evicted. When the first-level controller misses, it presents two things in the same cycle: the block address it wants, and the block its direct-mapped slot is about to give up. The buffer compares the requested address against every stored entry at once.

On a match, the stored block and its dirty flag go back to the controller. The slot that matched takes the block being evicted, so the two swap places. When no entry matches, a strobe forwards the request to the next level with the original address. The evicted block is then written into the slot chosen by a round-robin pointer. If that slot held a dirty block, that block leaves on the write-back output.

All results come from registers. They appear in the cycle after the request.

Top module: `victim_cache`

## Requirements
- R1: After reset every entry is empty. All outputs are low, and no address matches until a block has been inserted, including address 0.
- R2: For a request sampled on edge N, `rspValid` is high for exactly one cycle after edge N. With no request, `rspValid`, `fwdValid` and `wbValid` stay low.
- R3: On a miss, `fwdValid` is high in the same cycle as `rspValid`, with `rspHit` low and `fwdAddr` equal to the requested address. On a hit, `fwdValid` stays low.
- R4: On a hit, `rspHit` is high. `rspData` and `rspDirty` carry the data and dirty flag stored with the matching address.
- R5: On a hit with an eviction supplied, the matching slot takes the evicted block. Later lookups of the evicted address hit, and later lookups of the previously matched address miss.
- R6: On a hit with no eviction supplied, the matching entry becomes empty, so the next lookup of that address misses.
- R7: On a miss with an eviction supplied, the evicted block is written into the slot named by a round-robin pointer. The pointer starts at slot 0 after reset and advances by one, wrapping, on each such insert.
- R8: When an insert overwrites a valid dirty entry, `wbValid` is high in the response cycle, with `wbAddr` and `wbData` holding the displaced block. Overwriting a clean or empty entry leaves `wbValid` low.
- R9: A miss with no eviction supplied stores nothing and leaves the round-robin pointer unchanged.
- R10: A hit never moves the round-robin pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Lookup request from the first-level controller |
| reqAddr | input | ADDR_W | Block address being looked up |
| evValid | input | 1 | An evicted first-level block accompanies the request |
| evAddr | input | ADDR_W | Address of the evicted block |
| evDirty | input | 1 | Evicted block is modified |
| evData | input | DATA_W | Evicted block contents |
| rspValid | output | 1 | Lookup result is valid |
| rspHit | output | 1 | Lookup matched a stored entry |
| rspData | output | DATA_W | Block returned on a hit |
| rspDirty | output | 1 | Dirty flag of the returned block |
| fwdValid | output | 1 | Forward the request to the next level |
| fwdAddr | output | ADDR_W | Address forwarded to the next level |
| wbValid | output | 1 | A displaced dirty block must be written back |
| wbAddr | output | ADDR_W | Address of the displaced block |
| wbData | output | DATA_W | Contents of the displaced block |

## Verification
The hardest state to reach from the ports is a full buffer whose round-robin pointer lands on a dirty entry, after swaps and invalidations have left holes and replaced entries out of order. The stimulus table first fills every slot with a mix of clean and dirty blocks. A swap then sits between the fills and the wrap-around, so the pointer must skip over it untouched. An invalidating hit and an insert-free miss come next, so that a pointer which drifted would overwrite a block that a later row expects to hit. A reset in mid-run is then checked by looking up a block known to be resident.

// File: rtl/vc_pkg.sv
package vc_pkg;
  // Slot numbers are carried at a width large enough for the biggest supported buffer.
  localparam int SLOT_W = 3;

  typedef struct packed {
    logic              lookup;  // a request is being answered
    logic              hit;     // the request matched an entry
    logic              write;   // store the evicted block into slot
    logic              clear;   // empty the entry in slot
    logic [SLOT_W-1:0] slot;    // entry being read and/or written
  } vcStrobe_t;
endpackage

// File: rtl/vc_control.sv
module vc_control
  import vc_pkg::*;
#(
  parameter int ENTRIES = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic               evValid,
  input  logic [ENTRIES-1:0] hitVec,
  output vcStrobe_t          strb
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] rrPtr;
  logic [IDX_W-1:0] hitIdx;
  logic             hitAny;
  logic             insert;

  assign hitAny = |hitVec;

  always_comb begin
    hitIdx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hitVec[i]) hitIdx = IDX_W'(i);
    end
  end

  assign insert = reqValid && !hitAny && evValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rrPtr <= '0;
    end else if (insert) begin
      rrPtr <= (rrPtr == LAST) ? '0 : rrPtr + 1'b1;
    end
  end

  always_comb begin
    strb.lookup = reqValid;
    strb.hit    = reqValid && hitAny;
    strb.write  = reqValid && evValid;
    strb.clear  = reqValid && hitAny && !evValid;
    strb.slot   = SLOT_W'(hitAny ? hitIdx : rrPtr);
  end
endmodule

// File: rtl/vc_datapath.sv
module vc_datapath
  import vc_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 26,
  parameter int DATA_W  = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  vcStrobe_t          strb,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [ADDR_W-1:0]  evAddr,
  input  logic               evDirty,
  input  logic [DATA_W-1:0]  evData,
  output logic [ENTRIES-1:0] hitVec,
  output logic               rspValid,
  output logic               rspHit,
  output logic [DATA_W-1:0]  rspData,
  output logic               rspDirty,
  output logic               fwdValid,
  output logic [ADDR_W-1:0]  fwdAddr,
  output logic               wbValid,
  output logic [ADDR_W-1:0]  wbAddr,
  output logic [DATA_W-1:0]  wbData
);
  logic [ENTRIES-1:0] valid;
  logic [ENTRIES-1:0] dirty;
  logic [ENTRIES-1:0] selVec;
  logic [ADDR_W-1:0]  tagAddr [ENTRIES];
  logic [DATA_W-1:0]  blk     [ENTRIES];

  logic [ADDR_W-1:0] selAddr;
  logic [DATA_W-1:0] selData;
  logic              selValid;
  logic              selDirty;

  for (genvar g = 0; g < ENTRIES; g++) begin : gEntry
    assign hitVec[g] = valid[g] && (tagAddr[g] == reqAddr);
    assign selVec[g] = (strb.slot == SLOT_W'(g));
  end

  // Read port for the selected slot (returned block or displaced victim).
  always_comb begin
    selAddr  = '0;
    selData  = '0;
    selValid = 1'b0;
    selDirty = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (selVec[i]) begin
        selAddr  = tagAddr[i];
        selData  = blk[i];
        selValid = valid[i];
        selDirty = dirty[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      valid <= '0;
      dirty <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (strb.write && selVec[i]) begin
          valid[i] <= 1'b1;
          dirty[i] <= evDirty;
        end else if (strb.clear && selVec[i]) begin
          valid[i] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (strb.write && selVec[i]) begin
        tagAddr[i] <= evAddr;
        blk[i]     <= evData;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspHit   <= 1'b0;
      rspData  <= '0;
      rspDirty <= 1'b0;
      fwdValid <= 1'b0;
      fwdAddr  <= '0;
      wbValid  <= 1'b0;
      wbAddr   <= '0;
      wbData   <= '0;
    end else begin
      rspValid <= strb.lookup;
      rspHit   <= strb.hit;
      rspData  <= strb.hit ? selData : '0;
      rspDirty <= strb.hit && selDirty;
      fwdValid <= strb.lookup && !strb.hit;
      fwdAddr  <= reqAddr;
      wbValid  <= strb.write && !strb.hit && selValid && selDirty;
      wbAddr   <= selAddr;
      wbData   <= selData;
    end
  end
endmodule

// File: rtl/victim_cache.sv
module victim_cache
  import vc_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 26,
  parameter int DATA_W  = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              evValid,
  input  logic [ADDR_W-1:0] evAddr,
  input  logic              evDirty,
  input  logic [DATA_W-1:0] evData,
  output logic              rspValid,
  output logic              rspHit,
  output logic [DATA_W-1:0] rspData,
  output logic              rspDirty,
  output logic              fwdValid,
  output logic [ADDR_W-1:0] fwdAddr,
  output logic              wbValid,
  output logic [ADDR_W-1:0] wbAddr,
  output logic [DATA_W-1:0] wbData
);
  vcStrobe_t          strb;
  logic [ENTRIES-1:0] hitVec;

  vc_control #(.ENTRIES(ENTRIES)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .evValid(evValid),
    .hitVec(hitVec), .strb(strb)
  );

  vc_datapath #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqAddr(reqAddr),
    .evAddr(evAddr), .evDirty(evDirty), .evData(evData), .hitVec(hitVec),
    .rspValid(rspValid), .rspHit(rspHit), .rspData(rspData),
    .rspDirty(rspDirty), .fwdValid(fwdValid), .fwdAddr(fwdAddr),
    .wbValid(wbValid), .wbAddr(wbAddr), .wbData(wbData)
  );
endmodule

// File: rtl/vc_checker.sv
module vc_checker #(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 26
) (
  input logic               clk,
  input logic               rstN,
  input logic               reqValid,
  input logic [ADDR_W-1:0]  reqAddr,
  input logic               evValid,
  input logic [ENTRIES-1:0] hitVec,
  input logic               rspValid,
  input logic               rspHit,
  input logic               fwdValid,
  input logic [ADDR_W-1:0]  fwdAddr,
  input logic               wbValid
);
  a_r2_answer_follows: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  a_r2_quiet_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!rspValid && !fwdValid && !wbValid));

  a_r3_forward_iff_miss: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (fwdValid == !rspHit));

  a_r3_forward_address: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> (!fwdValid || fwdAddr == $past(reqAddr)));

  a_r8_writeback_on_insert: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> ($past(evValid) && fwdValid));

  // R4: an address is stored in at most one slot, so a lookup returns one block.
  a_r4_single_match: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));
endmodule

bind victim_cache vc_checker #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_vcChk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
  .evValid(evValid), .hitVec(hitVec), .rspValid(rspValid), .rspHit(rspHit),
  .fwdValid(fwdValid), .fwdAddr(fwdAddr), .wbValid(wbValid)
);

// File: tb/sim_victim_cache.sv
`timescale 1ns/1ps
module sim_victim_cache;
  localparam int AW = 26;
  localparam int DW = 64;
  localparam int NV = 17;

  typedef struct packed {
    logic [AW-1:0] reqA;
    logic          evV;
    logic [AW-1:0] evA;
    logic          evD;
    logic          expHit;
    logic          expDirty;
    logic          expWb;
    logic [AW-1:0] wbA;
  } vec_t;

  // Four slots, pointer starts at 0. Comments give the slot state after each row.
  localparam vec_t VECS [NV] = '{
    '{26'h000, 1'b0, 26'h000, 1'b0, 1'b0, 1'b0, 1'b0, 26'h0},   // R1 empty: addr 0 misses
    '{26'h100, 1'b1, 26'h010, 1'b0, 1'b0, 1'b0, 1'b0, 26'h0},   // R7 s0=010c
    '{26'h101, 1'b1, 26'h011, 1'b1, 1'b0, 1'b0, 1'b0, 26'h0},   // s1=011d
    '{26'h102, 1'b1, 26'h012, 1'b0, 1'b0, 1'b0, 1'b0, 26'h0},   // s2=012c
    '{26'h103, 1'b1, 26'h013, 1'b1, 1'b0, 1'b0, 1'b0, 26'h0},   // s3=013d, ptr wraps
    '{26'h011, 1'b1, 26'h020, 1'b0, 1'b1, 1'b1, 1'b0, 26'h0},   // R5 R10 swap s1=020c
    '{26'h104, 1'b1, 26'h021, 1'b1, 1'b0, 1'b0, 1'b0, 26'h0},   // R8 clean s0 replaced
    '{26'h105, 1'b1, 26'h022, 1'b0, 1'b0, 1'b0, 1'b0, 26'h0},   // s1=022c
    '{26'h106, 1'b1, 26'h023, 1'b0, 1'b0, 1'b0, 1'b0, 26'h0},   // s2=023c
    '{26'h107, 1'b1, 26'h024, 1'b0, 1'b0, 1'b0, 1'b1, 26'h013}, // R8 dirty 013 out
    '{26'h021, 1'b0, 26'h000, 1'b0, 1'b1, 1'b1, 1'b0, 26'h0},   // R6 s0 emptied
    '{26'h021, 1'b0, 26'h000, 1'b0, 1'b0, 1'b0, 1'b0, 26'h0},   // R6 R9 miss, no store
    '{26'h011, 1'b1, 26'h030, 1'b1, 1'b0, 1'b0, 1'b0, 26'h0},   // R5 R9 s0=030d
    '{26'h022, 1'b0, 26'h000, 1'b0, 1'b1, 1'b0, 1'b0, 26'h0},   // R9 s1 survived
    '{26'h020, 1'b0, 26'h000, 1'b0, 1'b0, 1'b0, 1'b0, 26'h0},   // R7 020 overwritten
    '{26'h030, 1'b1, 26'h040, 1'b0, 1'b1, 1'b1, 1'b0, 26'h0},   // R4 s0=040c
    '{26'h040, 1'b0, 26'h000, 1'b0, 1'b1, 1'b0, 1'b0, 26'h0}    // R5 swapped-in hits
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic          evValid = 1'b0;
  logic [AW-1:0] evAddr = '0;
  logic          evDirty = 1'b0;
  logic [DW-1:0] evData = '0;
  logic          rspValid, rspHit, rspDirty, fwdValid, wbValid;
  logic [DW-1:0] rspData, wbData;
  logic [AW-1:0] fwdAddr, wbAddr;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  victim_cache #(.ENTRIES(4), .ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .evValid(evValid), .evAddr(evAddr), .evDirty(evDirty), .evData(evData),
    .rspValid(rspValid), .rspHit(rspHit), .rspData(rspData),
    .rspDirty(rspDirty), .fwdValid(fwdValid), .fwdAddr(fwdAddr),
    .wbValid(wbValid), .wbAddr(wbAddr), .wbData(wbData)
  );

  function automatic logic [DW-1:0] dataOf(input logic [AW-1:0] a);
    return {6'h2A, a, 6'h15, ~a};
  endfunction

  task automatic chk(input bit ok, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [AW-1:0] a,
                       input logic ev, input logic [AW-1:0] ea, input logic ed);
    reqValid = v;
    reqAddr  = a;
    evValid  = ev;
    evAddr   = ea;
    evDirty  = ed;
    evData   = dataOf(ea);
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs low while reset is held
    chk(!rspValid && !fwdValid && !wbValid && !rspHit, "R1 reset outputs",
        {61'b0, rspValid, fwdValid, wbValid}, 64'h0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(1'b1, VECS[i].reqA, VECS[i].evV, VECS[i].evA, VECS[i].evD);
      @(negedge clk);
      chk(rspValid == 1'b1, $sformatf("R2 row%0d rspValid", i), 64'(rspValid), 64'h1);
      chk(rspHit == VECS[i].expHit, $sformatf("R4 row%0d rspHit", i),
          64'(rspHit), 64'(VECS[i].expHit));
      if (VECS[i].expHit) begin
        chk(rspData == dataOf(VECS[i].reqA), $sformatf("R4 row%0d rspData", i),
            rspData, dataOf(VECS[i].reqA));
        chk(rspDirty == VECS[i].expDirty, $sformatf("R4 row%0d rspDirty", i),
            64'(rspDirty), 64'(VECS[i].expDirty));
        chk(!fwdValid, $sformatf("R3 row%0d no forward on hit", i), 64'(fwdValid), 64'h0);
      end else begin
        chk(fwdValid && fwdAddr == VECS[i].reqA, $sformatf("R3 row%0d forward", i),
            64'(fwdAddr), 64'(VECS[i].reqA));
      end
      chk(wbValid == VECS[i].expWb, $sformatf("R8 row%0d wbValid", i),
          64'(wbValid), 64'(VECS[i].expWb));
      if (VECS[i].expWb) begin
        chk(wbAddr == VECS[i].wbA, $sformatf("R8 row%0d wbAddr", i),
            64'(wbAddr), 64'(VECS[i].wbA));
        chk(wbData == dataOf(VECS[i].wbA), $sformatf("R8 row%0d wbData", i),
            wbData, dataOf(VECS[i].wbA));
      end
    end

    // R2: an idle cycle produces no response, forward or write-back
    drive(1'b0, 26'h023, 1'b1, 26'h055, 1'b1);
    @(negedge clk);
    chk(!rspValid && !fwdValid && !wbValid, "R2 idle quiet",
        {61'b0, rspValid, fwdValid, wbValid}, 64'h0);
    // R2: the idle eviction was ignored, so 055 is not stored and 023 still hits
    drive(1'b1, 26'h055, 1'b0, 26'h0, 1'b0);
    @(negedge clk);
    chk(!rspHit && fwdValid, "R2 idle eviction not stored", 64'(rspHit), 64'h0);
    drive(1'b1, 26'h023, 1'b0, 26'h0, 1'b0);
    @(negedge clk);
    chk(rspHit && rspData == dataOf(26'h023), "R4 resident block before reset",
        rspData, dataOf(26'h023));

    // R1: mid-run reset empties the buffer (024 is resident and untouched)
    drive(1'b0, '0, 1'b0, '0, 1'b0);
    rstN = 1'b0;
    @(negedge clk);
    chk(!rspValid && !fwdValid && !wbValid, "R1 outputs cleared by reset",
        {61'b0, rspValid, fwdValid, wbValid}, 64'h0);
    rstN = 1'b1;
    drive(1'b1, 26'h024, 1'b0, '0, 1'b0);
    @(negedge clk);
    chk(!rspHit && fwdValid, "R1 no match after reset", 64'(rspHit), 64'h0);
    // R7: pointer restarts at slot 0: fill four, the fifth insert displaces the first (dirty)
    for (int k = 0; k < 5; k++) begin
      drive(1'b1, 26'h200 + AW'(k), 1'b1, 26'h300 + AW'(k), 1'b1);
      @(negedge clk);
      if (k == 4)
        chk(wbValid && wbAddr == 26'h300, "R7 wrap displaces slot 0",
            64'(wbAddr), 64'h300);
      else
        chk(!wbValid, "R7 fill after reset no write-back", 64'(wbValid), 64'h0);
    end
    drive(1'b0, '0, 1'b0, '0, 1'b0);
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule